// File: doc/BRIEF.md
# USB Receive Endpoint Status Controller

This block keeps the control and status byte of a single USB receive endpoint and owns the endpoint's receive-ready flag. The protocol engine reports each received packet with a one-cycle event. The block then raises the ready flag, requests DMA service when that is enabled, and for bulk or interrupt traffic chooses whether the handshake is ACK or NYET. Software or the DMA engine drains the receive FIFO, and the block counts each unloaded byte. A CPU unload adds its stated byte count. A DMA unload always adds four.

When auto-clear is enabled, the ready flag drops by itself once the count of unloaded bytes reaches the programmed maximum packet size. A shorter packet leaves the flag set until software clears it. Bit 4 of the byte has two meanings. In bulk or interrupt mode it is a control bit that forces ACK in every case. In isochronous mode it is a sticky status bit that records a PID error in a received packet.

Top module: `usb_rxep_status`

## Requirements
- R1: After reset the register reads 0x00, and rx_ready, dma_req, hs_vld and hs_nyet are all 0.
- R2: Register bits 3..0 always read 0, and writing them has no effect. Bit 7 is auto-clear, bit 6 is the mode (0 isochronous, 1 bulk/interrupt), bit 5 is the DMA enable and bit 4 is the dual-meaning bit. Each of these reads back the value written, except bit 4 in isochronous mode (R9).
- R3: A pkt_rcvd pulse sets rx_ready on the next clock. A ready_clr pulse clears it. If both arrive in the same cycle, pkt_rcvd wins.
- R4: While rx_ready is 1 and bit 7 is 1, an unload that brings the byte count to or past max_pkt clears rx_ready on the next clock. A DMA unload (unload_dma=1) adds 4 bytes. A CPU unload adds unload_bytes.
- R5: When the unloaded total stays below max_pkt, or bit 7 is 0, rx_ready stays set until ready_clr.
- R6: The byte count restarts at 0 whenever rx_ready clears, by any cause, and on every pkt_rcvd.
- R7: dma_req is 1 exactly when bit 5 is 1 and rx_ready is 1.
- R8: The cycle after a pkt_rcvd in bulk mode (bit 6 = 1), hs_vld is 1. hs_nyet is 1 only when bit 4 is 0 and fifo_free < max_pkt; otherwise the handshake is ACK (hs_nyet = 0).
- R9: In isochronous mode hs_vld stays 0. A pkt_rcvd with pkt_pid_err sets bit 4. A write that keeps bit 6 at 0 can clear bit 4 by writing 0 to it, but cannot set it by writing 1.
- R10: Unload strobes while rx_ready is 0 are ignored and do not advance the byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_data | output | 8 | Register read value |
| ready_clr | input | 1 | Software clear of the ready flag |
| max_pkt | input | CNT_W (11) | Programmed maximum packet size in bytes |
| unload_vld | input | 1 | FIFO unload strobe |
| unload_dma | input | 1 | Unload comes from DMA (4-byte chunk) |
| unload_bytes | input | 3 | Bytes taken by a CPU unload |
| pkt_rcvd | input | 1 | Packet-received event from the protocol engine |
| pkt_pid_err | input | 1 | Received packet had a PID error |
| fifo_free | input | FREE_W (12) | FIFO space left after the current packet |
| rx_ready | output | 1 | Receive-ready flag |
| dma_req | output | 1 | DMA service request |
| hs_vld | output | 1 | Handshake decision valid |
| hs_nyet | output | 1 | 1 = answer NYET, 0 = answer ACK |

## Verification
The bench checks that a chain of 4-byte DMA chunks clears the flag exactly on the chunk that reaches max_pkt. A design that compared for equality only, or counted DMA unloads as single bytes, would leave the flag set or clear it late. A short packet and a pkt_rcvd arriving after a partial unload are both run: a counter that did not restart would clear the next packet early, and an over-eager compare would clear a short packet. Bit 4 is exercised in both modes. In isochronous mode a write of 1 must not fake a PID error, and a write of 0 must erase one. A forced-ACK error would show as NYET against a nearly full FIFO. Random traffic, which includes simultaneous clear and packet events, is compared every cycle against a bench model.

// File: rtl/usb_rxep_pkg.sv
package usb_rxep_pkg;
  localparam int BIT_AUTO = 7;
  localparam int BIT_MODE = 6;
  localparam int BIT_DMA  = 5;
  localparam int BIT_DUAL = 4;
  localparam int DMA_CHUNK = 4;

  typedef struct packed {
    logic auto_clr;
    logic bulk;
    logic dma_en;
    logic dual;
  } ctrl_t;
endpackage

// File: rtl/rxep_ctrl_reg.sv
module rxep_ctrl_reg
  import usb_rxep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       pkt_rcvd,
  input  logic       pkt_pid_err,
  output ctrl_t      ctrl,
  output logic [7:0] rd_data
);
  ctrl_t ctrl_q, ctrl_d;
  logic  pid_set;
  logic  ld;

  assign pid_set = pkt_rcvd & pkt_pid_err & ~ctrl_q.bulk;
  assign ld      = wr_en | pid_set;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d.auto_clr = wr_data[BIT_AUTO];
      ctrl_d.bulk     = wr_data[BIT_MODE];
      ctrl_d.dma_en   = wr_data[BIT_DMA];
      if (wr_data[BIT_MODE]) ctrl_d.dual = wr_data[BIT_DUAL];
      else                   ctrl_d.dual = ctrl_q.dual & wr_data[BIT_DUAL];
    end
    if (pid_set) ctrl_d.dual = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctrl_q <= '0;
    else if (ld) ctrl_q <= ctrl_d;
  end

  assign ctrl    = ctrl_q;
  assign rd_data = {ctrl_q.auto_clr, ctrl_q.bulk, ctrl_q.dma_en, ctrl_q.dual, 4'b0000};

  // R9: in isochronous mode a write cannot create a PID error
  p_iso_no_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[BIT_MODE] && !ctrl_q.dual && !pid_set) |=> !rd_data[BIT_DUAL]);
  // R9: a PID error event in isochronous mode is recorded
  p_pid_record_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_rcvd && pkt_pid_err && !rd_data[BIT_MODE]) |=> rd_data[BIT_DUAL]);
endmodule

// File: rtl/rxep_ready_tracker.sv
module rxep_ready_tracker
  import usb_rxep_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_clr,
  input  logic [CNT_W-1:0] max_pkt,
  input  logic             unload_vld,
  input  logic             unload_dma,
  input  logic [2:0]       unload_bytes,
  input  logic             pkt_rcvd,
  input  logic             ready_clr,
  output logic             rx_ready
);
  localparam int ACC_W = CNT_W + 1;

  logic             rdy_q, rdy_d;
  logic [ACC_W-1:0] cnt_q, cnt_d;
  logic [ACC_W:0]   sum_w;
  logic [ACC_W-1:0] sum;
  logic [2:0]       step;
  logic             reach;
  logic             ld;

  assign step  = unload_dma ? 3'(DMA_CHUNK) : unload_bytes;
  assign sum_w = {1'b0, cnt_q} + (ACC_W+1)'(step);
  assign sum   = sum_w[ACC_W] ? {ACC_W{1'b1}} : sum_w[ACC_W-1:0];
  assign reach = auto_clr & (sum >= ACC_W'(max_pkt));
  assign ld    = pkt_rcvd | ready_clr | (rdy_q & unload_vld);

  always_comb begin
    rdy_d = rdy_q;
    cnt_d = cnt_q;
    if (pkt_rcvd) begin
      rdy_d = 1'b1;
      cnt_d = '0;
    end else if (ready_clr) begin
      rdy_d = 1'b0;
      cnt_d = '0;
    end else if (rdy_q && unload_vld) begin
      if (reach) begin
        rdy_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      cnt_q <= '0;
    end else if (ld) begin
      rdy_q <= rdy_d;
      cnt_q <= cnt_d;
    end
  end

  assign rx_ready = rdy_q;

  // R3: a packet event always leaves the flag set
  p_pkt_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_rcvd |=> rx_ready);
  // R5: without auto-clear only software drops the flag
  p_manual_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && !auto_clr && !ready_clr && !pkt_rcvd) |=> rx_ready);
  // R10 / R6: the count is idle at zero while no packet is ready
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> (cnt_q == '0));
endmodule

// File: rtl/rxep_handshake.sv
module rxep_handshake #(
  parameter int CNT_W  = 11,
  parameter int FREE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_rcvd,
  input  logic              bulk,
  input  logic              nyet_dis,
  input  logic [FREE_W-1:0] fifo_free,
  input  logic [CNT_W-1:0]  max_pkt,
  output logic              hs_vld,
  output logic              hs_nyet
);
  localparam int CW = (FREE_W > CNT_W) ? FREE_W : CNT_W;

  logic vld_q, vld_d, nyet_q, nyet_d;
  logic tight;

  assign tight  = CW'(fifo_free) < CW'(max_pkt);
  assign vld_d  = pkt_rcvd & bulk;
  assign nyet_d = vld_d & ~nyet_dis & tight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      nyet_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      nyet_q <= nyet_d;
    end
  end

  assign hs_vld  = vld_q;
  assign hs_nyet = nyet_q;

  // R8: NYET disabled means every bulk packet is acknowledged
  p_forced_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_rcvd && bulk && nyet_dis) |=> (hs_vld && !hs_nyet));
  // R9: isochronous packets get no handshake
  p_iso_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_rcvd && !bulk) |=> !hs_vld);
  // R8: NYET never appears without a valid decision
  p_nyet_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hs_nyet |-> hs_vld);
endmodule

// File: rtl/usb_rxep_status.sv
module usb_rxep_status
  import usb_rxep_pkg::*;
#(
  parameter int CNT_W  = 11,
  parameter int FREE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [7:0]        reg_wr_data,
  output logic [7:0]        reg_rd_data,
  input  logic              ready_clr,
  input  logic [CNT_W-1:0]  max_pkt,
  input  logic              unload_vld,
  input  logic              unload_dma,
  input  logic [2:0]        unload_bytes,
  input  logic              pkt_rcvd,
  input  logic              pkt_pid_err,
  input  logic [FREE_W-1:0] fifo_free,
  output logic              rx_ready,
  output logic              dma_req,
  output logic              hs_vld,
  output logic              hs_nyet
);
  ctrl_t ctrl;

  rxep_ctrl_reg u_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (reg_wr_en),
    .wr_data     (reg_wr_data),
    .pkt_rcvd    (pkt_rcvd),
    .pkt_pid_err (pkt_pid_err),
    .ctrl        (ctrl),
    .rd_data     (reg_rd_data)
  );

  rxep_ready_tracker #(.CNT_W(CNT_W)) u_trk (
    .clk          (clk),
    .rst_n        (rst_n),
    .auto_clr     (ctrl.auto_clr),
    .max_pkt      (max_pkt),
    .unload_vld   (unload_vld),
    .unload_dma   (unload_dma),
    .unload_bytes (unload_bytes),
    .pkt_rcvd     (pkt_rcvd),
    .ready_clr    (ready_clr),
    .rx_ready     (rx_ready)
  );

  rxep_handshake #(.CNT_W(CNT_W), .FREE_W(FREE_W)) u_hs (
    .clk       (clk),
    .rst_n     (rst_n),
    .pkt_rcvd  (pkt_rcvd),
    .bulk      (ctrl.bulk),
    .nyet_dis  (ctrl.dual),
    .fifo_free (fifo_free),
    .max_pkt   (max_pkt),
    .hs_vld    (hs_vld),
    .hs_nyet   (hs_nyet)
  );

  assign dma_req = ctrl.dma_en & rx_ready;

  // R7: an enabled endpoint requests DMA right after a packet arrives
  p_dma_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_rcvd && reg_rd_data[BIT_DMA] && !reg_wr_en) |=> dma_req);
  // R7: the request drops together with the ready flag
  p_dma_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> !dma_req);
endmodule

// File: tb/tb_usb_rxep_status.sv
`timescale 1ns/1ps
module tb_usb_rxep_status;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [7:0]  reg_wr_data;
  logic [7:0]  reg_rd_data;
  logic        ready_clr;
  logic [10:0] max_pkt;
  logic        unload_vld, unload_dma;
  logic [2:0]  unload_bytes;
  logic        pkt_rcvd, pkt_pid_err;
  logic [11:0] fifo_free;
  logic        rx_ready, dma_req, hs_vld, hs_nyet;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // bench model state
  bit m_auto, m_bulk, m_dma, m_dual, m_rdy, m_hsv, m_hsn;
  int m_cnt;

  always #4 clk = ~clk;

  usb_rxep_status dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .ready_clr(ready_clr), .max_pkt(max_pkt),
    .unload_vld(unload_vld), .unload_dma(unload_dma), .unload_bytes(unload_bytes),
    .pkt_rcvd(pkt_rcvd), .pkt_pid_err(pkt_pid_err), .fifo_free(fifo_free),
    .rx_ready(rx_ready), .dma_req(dma_req), .hs_vld(hs_vld), .hs_nyet(hs_nyet)
  );

  function automatic logic [7:0] exp_rd();
    return {m_auto, m_bulk, m_dma, m_dual, 4'b0000};
  endfunction

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit n_auto, n_bulk, n_dma, n_dual, n_rdy;
    int sum, n_cnt, stp;
    n_auto = m_auto; n_bulk = m_bulk; n_dma = m_dma; n_dual = m_dual;
    if (reg_wr_en) begin
      n_auto = reg_wr_data[7];
      n_bulk = reg_wr_data[6];
      n_dma  = reg_wr_data[5];
      n_dual = reg_wr_data[6] ? reg_wr_data[4] : (m_dual & reg_wr_data[4]);
    end
    if (pkt_rcvd && pkt_pid_err && !m_bulk) n_dual = 1'b1;
    stp = unload_dma ? 4 : int'(unload_bytes);
    sum = m_cnt + stp;
    if (sum > 4095) sum = 4095;
    n_rdy = m_rdy; n_cnt = m_cnt;
    if (pkt_rcvd) begin n_rdy = 1; n_cnt = 0; end
    else if (ready_clr) begin n_rdy = 0; n_cnt = 0; end
    else if (m_rdy && unload_vld) begin
      if (m_auto && sum >= int'(max_pkt)) begin n_rdy = 0; n_cnt = 0; end
      else n_cnt = sum;
    end
    m_hsv = pkt_rcvd && m_bulk;
    m_hsn = m_hsv && !m_dual && (int'(fifo_free) < int'(max_pkt));
    m_auto = n_auto; m_bulk = n_bulk; m_dma = n_dma; m_dual = n_dual;
    m_rdy = n_rdy; m_cnt = n_cnt;
  endtask

  task automatic compare();
    chk("reg_rd_data", reg_rd_data, exp_rd());
    chk("rx_ready", rx_ready, m_rdy);
    chk("dma_req", dma_req, m_dma & m_rdy);
    chk("hs_vld", hs_vld, m_hsv);
    chk("hs_nyet", hs_nyet, m_hsn);
  endtask

  task automatic idle_inputs();
    reg_wr_en = 0; reg_wr_data = 0; ready_clr = 0; unload_vld = 0;
    unload_dma = 0; unload_bytes = 0; pkt_rcvd = 0; pkt_pid_err = 0;
  endtask

  task automatic cyc();
    model_step();
    @(negedge clk);
    compare();
    idle_inputs();
  endtask

  task automatic wr(logic [7:0] d);
    reg_wr_en = 1; reg_wr_data = d; cyc();
  endtask

  task automatic pkt(bit err);
    pkt_rcvd = 1; pkt_pid_err = err; cyc();
  endtask

  task automatic unload(bit dma, int n);
    unload_vld = 1; unload_dma = dma; unload_bytes = 3'(n); cyc();
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle_inputs();
    max_pkt = 11'd16; fifo_free = 12'd100;
    rst_n = 0;
    {m_auto, m_bulk, m_dma, m_dual, m_rdy, m_hsv, m_hsn} = '0;
    m_cnt = 0;
    repeat (3) @(negedge clk);
    tag = "R1 reset";
    compare();
    rst_n = 1;
    cyc();

    tag = "R2 reserved";
    wr(8'hCF);
    chk("R2 direct", reg_rd_data, 8'hC0);

    tag = "R9 iso pid";
    wr(8'h00);
    pkt(1);
    chk("R9 pid set", reg_rd_data[4], 1);
    wr(8'h10);
    wr(8'h00);
    chk("R9 pid cleared", reg_rd_data[4], 0);
    wr(8'h10);
    chk("R9 write 1 no set", reg_rd_data[4], 0);
    ready_clr = 1; cyc();

    tag = "R4 dma autoclear";
    wr(8'hA0);
    pkt(0);
    chk("R7 dma_req", dma_req, 1);
    for (int i = 0; i < 3; i++) unload(1, 0);
    chk("R4 still ready", rx_ready, 1);
    unload(1, 0);
    chk("R4 cleared", rx_ready, 0);

    tag = "R5 short packet";
    wr(8'h80);
    pkt(0);
    unload(0, 3); unload(0, 3);
    chk("R5 short holds", rx_ready, 1);
    ready_clr = 1; cyc();
    chk("R5 manual clear", rx_ready, 0);

    tag = "R6 count restart";
    pkt(0);
    for (int i = 0; i < 3; i++) unload(1, 0);
    pkt(0);
    unload(1, 0);
    chk("R6 restart holds", rx_ready, 1);
    for (int i = 0; i < 3; i++) unload(1, 0);
    chk("R6 cleared", rx_ready, 0);

    tag = "R10 ignore idle unload";
    for (int i = 0; i < 4; i++) unload(1, 0);
    pkt(0);
    for (int i = 0; i < 3; i++) unload(1, 0);
    chk("R10 not advanced", rx_ready, 1);
    ready_clr = 1; cyc();

    tag = "R8 handshake";
    wr(8'h40);
    fifo_free = 12'd10; pkt(0);
    chk("R8 nyet", hs_nyet, 1);
    fifo_free = 12'd40; pkt(0);
    chk("R8 ack room", hs_nyet, 0);
    wr(8'h50);
    fifo_free = 12'd0; pkt(0);
    chk("R8 forced ack", {hs_vld, hs_nyet}, 2'b10);

    tag = "R3 pkt beats clear";
    ready_clr = 1; cyc();
    pkt_rcvd = 1; ready_clr = 1; cyc();
    chk("R3 set wins", rx_ready, 1);

    tag = "R3 R4 R7 R8 random";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (i % 500 == 0) max_pkt = 11'($urandom_range(4, 40));
      fifo_free = 12'($urandom_range(0, 80));
      if (r < 6) begin
        reg_wr_en = 1; reg_wr_data = 8'($urandom);
      end
      if (r >= 6 && r < 14) begin
        pkt_rcvd = 1; pkt_pid_err = 1'($urandom);
      end
      if (r >= 10 && r < 18) ready_clr = ($urandom_range(0, 3) == 0);
      if (r >= 30) begin
        unload_vld = 1; unload_dma = 1'($urandom);
        unload_bytes = 3'($urandom_range(1, 4));
      end
      cyc();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule